// File: doc/BRIEF.md
# Serial Flash Command Frame Validator

This block sits behind the slave pins of a serial flash command port. It samples the chip select, serial clock and data-in lines with the system clock and collects the bits of each frame, most significant bit first. It keeps the opcode, up to three address bytes and a count of the clock pulses seen since chip select fell. When chip select returns high, it checks the frame against the length rule of its opcode. It then raises either an execute strobe, carrying the opcode, the address and the number of whole bytes after the opcode, or a reject strobe.

Commands that modify flash state are accepted only when the frame ends exactly on a byte boundary. Erase commands must carry exactly the address and nothing more. A program command must carry the address plus at least one data byte. Read-class commands may be cut off at any bit. While the downstream engine reports a program, erase or status-write cycle in progress, commands that touch the array are rejected. The status read stays usable so that the host can poll. The array, the data-out path and the program/erase timing engines sit downstream and are not part of this block.

Top module: `spi_cmd_validator`

## Requirements
- R1: Bits are taken on rising serial-clock edges while chip select is low, MSB first. The first byte of a frame is the opcode. Bytes 1 to 3 shift into `cmd_addr` big-endian (byte 1 ends in bits 23:16 when all three arrive; fewer bytes stay right-aligned). Every field starts from zero in each frame.
- R2: Every rising edge of chip select produces exactly one one-cycle pulse, on either `exec_stb` or `rej_stb`, and never on both. Neither pulse appears at any other time.
- R3: A frame with fewer than 8 clocks is rejected. So is a frame whose opcode is not one of 06h, 04h, 05h, 01h, 03h, 0Bh, 02h, 20h, D8h, C7h, B9h, ABh.
- R4: The state-changing opcodes are write enable 06h, write disable 04h, status write 01h, page program 02h, sector erase 20h, block erase D8h, chip erase C7h and power-down B9h. They are rejected unless the clock count is a multiple of 8.
- R5: The read-class opcodes (read 03h, fast read 0Bh, status read 05h, wake/ID ABh) execute for any clock count of 8 or more. `cmd_nbytes` is floor(clocks/8) minus 1.
- R6: Sector erase 20h and block erase D8h execute only when exactly 3 whole bytes follow the opcode.
- R7: Page program 02h executes only when at least 4 whole bytes follow the opcode.
- R8: Status write 01h executes only when at least 1 whole byte follows the opcode.
- R9: While `busy` is high at chip select rise, the array opcodes (03h, 0Bh, 02h, 20h, D8h, C7h) are rejected. Status read 05h still executes.
- R10: Serial-clock edges while chip select is high are ignored and do not change the following frame's result.
- R11: After reset both strobes are low and `cmd_op`, `cmd_addr` and `cmd_nbytes` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| busy | input | 1 | Program/erase/status-write cycle in progress |
| exec_stb | output | 1 | One-cycle pulse: frame accepted |
| rej_stb | output | 1 | One-cycle pulse: frame refused |
| cmd_op | output | 8 | Opcode of the frame just closed |
| cmd_addr | output | 8*ADDR_BYTES | Captured address bytes |
| cmd_nbytes | output | CNT_W-3 | Whole bytes after the opcode |

## Verification
The bench builds the block with its defaults: two synchronizer stages, three address bytes and a 12-bit clock counter. With these settings the 24-bit address path and both byte-boundary outcomes are exercised. So are the exact-length erase rule on both sides (2 and 4 bytes), the program minimum and a partial final byte. The counter never saturates in these frames, so `cmd_nbytes` for mid-byte read terminations can be predicted exactly.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_FREAD = 8'h0B;
   localparam logic [7:0] OP_PROG  = 8'h02;
   localparam logic [7:0] OP_SERA  = 8'h20;
   localparam logic [7:0] OP_BERA  = 8'hD8;
   localparam logic [7:0] OP_CERA  = 8'hC7;
   localparam logic [7:0] OP_PDWN  = 8'hB9;
   localparam logic [7:0] OP_WAKE  = 8'hAB;

   typedef enum logic [2:0] {
      CL_BAD,
      CL_READ,
      CL_PLAIN,
      CL_STWR,
      CL_PROG,
      CL_ERASE
   } op_class_e;

   function automatic op_class_e op_class(input logic [7:0] op);
      case (op)
         OP_READ, OP_FREAD, OP_RDSR, OP_WAKE: op_class = CL_READ;
         OP_WREN, OP_WRDI, OP_CERA, OP_PDWN:  op_class = CL_PLAIN;
         OP_WRSR:                             op_class = CL_STWR;
         OP_PROG:                             op_class = CL_PROG;
         OP_SERA, OP_BERA:                    op_class = CL_ERASE;
         default:                             op_class = CL_BAD;
      endcase
   endfunction

   function automatic logic touches_array(input logic [7:0] op);
      case (op)
         OP_READ, OP_FREAD, OP_PROG, OP_SERA, OP_BERA, OP_CERA: touches_array = 1'b1;
         default:                                               touches_array = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic sck_i,
   input  logic mosi_i,
   output logic sel_o,
   output logic sck_rise_o,
   output logic mosi_o,
   output logic end_o,
   output logic idle_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] cs_p, sck_p, mosi_p;
   logic              cs_last, sck_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_p[0]   <= 1'b1;
         sck_p[0]  <= 1'b0;
         mosi_p[0] <= 1'b0;
      end else begin
         cs_p[0]   <= cs_n_i;
         sck_p[0]  <= sck_i;
         mosi_p[0] <= mosi_i;
      end
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cs_p[s]   <= 1'b1;
            sck_p[s]  <= 1'b0;
            mosi_p[s] <= 1'b0;
         end else begin
            cs_p[s]   <= cs_p[s-1];
            sck_p[s]  <= sck_p[s-1];
            mosi_p[s] <= mosi_p[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_last  <= 1'b1;
         sck_last <= 1'b0;
      end else begin
         cs_last  <= cs_p[STAGES-1];
         sck_last <= sck_p[STAGES-1];
      end
   end

   assign sel_o      = ~cs_p[STAGES-1];
   assign sck_rise_o = sel_o & sck_p[STAGES-1] & ~sck_last;
   assign mosi_o     = mosi_p[STAGES-1];
   assign end_o      = cs_p[STAGES-1] & ~cs_last;
   assign idle_o     = cs_p[STAGES-1] & cs_last;
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
   parameter int ADDR_BYTES = 3,
   parameter int CNT_W      = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear_i,
   input  logic                    bit_i,
   input  logic                    mosi_i,
   output logic [CNT_W-1:0]        nbits_o,
   output logic [7:0]              op_o,
   output logic [8*ADDR_BYTES-1:0] addr_o
);
   localparam int AW = 8 * ADDR_BYTES;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [7:0]       sh;
   logic [7:0]       nxt_byte;
   logic             byte_done;
   logic [CNT_W-4:0] byte_idx;

   assign nxt_byte  = {sh[6:0], mosi_i};
   assign byte_done = bit_i && (nbits_o[2:0] == 3'd7) && (nbits_o != CNT_MAX);
   assign byte_idx  = nbits_o[CNT_W-1:3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nbits_o <= '0;
         sh      <= '0;
         op_o    <= '0;
      end else if (clear_i) begin
         nbits_o <= '0;
         sh      <= '0;
         op_o    <= '0;
      end else if (bit_i) begin
         sh <= nxt_byte;
         if (nbits_o != CNT_MAX) nbits_o <= nbits_o + 1'b1;
         if (byte_done && byte_idx == '0) op_o <= nxt_byte;
      end
   end

   logic take_addr;
   assign take_addr = byte_done && (byte_idx != '0) &&
                      (int'(byte_idx) <= ADDR_BYTES);

   if (ADDR_BYTES == 1) begin : g_addr1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         addr_o <= '0;
         else if (clear_i)   addr_o <= '0;
         else if (take_addr) addr_o <= nxt_byte;
      end
   end else begin : g_addrn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         addr_o <= '0;
         else if (clear_i)   addr_o <= '0;
         else if (take_addr) addr_o <= {addr_o[AW-9:0], nxt_byte};
      end
   end
endmodule

// File: rtl/spi_frame_judge.sv
module spi_frame_judge
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   parameter int CNT_W      = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    end_i,
   input  logic                    busy_i,
   input  logic [CNT_W-1:0]        nbits_i,
   input  logic [7:0]              op_i,
   input  logic [8*ADDR_BYTES-1:0] addr_i,
   output logic                    exec_o,
   output logic                    rej_o,
   output logic [7:0]              op_o,
   output logic [8*ADDR_BYTES-1:0] addr_o,
   output logic [CNT_W-4:0]        nbytes_o
);
   localparam int NB_W = CNT_W - 3;
   localparam logic [NB_W-1:0] NB_ERASE = NB_W'(ADDR_BYTES);
   localparam logic [NB_W-1:0] NB_PROG  = NB_W'(ADDR_BYTES + 1);

   logic            whole, has_op, ok;
   logic [NB_W-1:0] all_bytes, after_op;
   op_class_e       cls;

   assign whole     = (nbits_i[2:0] == 3'd0);
   assign all_bytes = nbits_i[CNT_W-1:3];
   assign has_op    = (all_bytes != '0);
   assign after_op  = has_op ? all_bytes - 1'b1 : '0;
   assign cls       = op_class(op_i);

   always_comb begin
      case (cls)
         CL_READ:  ok = 1'b1;
         CL_PLAIN: ok = whole;
         CL_STWR:  ok = whole && (after_op >= NB_W'(1));
         CL_PROG:  ok = whole && (after_op >= NB_PROG);
         CL_ERASE: ok = whole && (after_op == NB_ERASE);
         default:  ok = 1'b0;
      endcase
      if (!has_op) ok = 1'b0;
      if (busy_i && touches_array(op_i)) ok = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exec_o   <= 1'b0;
         rej_o    <= 1'b0;
         op_o     <= '0;
         addr_o   <= '0;
         nbytes_o <= '0;
      end else begin
         exec_o <= end_i && ok;
         rej_o  <= end_i && !ok;
         if (end_i) begin
            op_o     <= op_i;
            addr_o   <= addr_i;
            nbytes_o <= after_op;
         end
      end
   end
endmodule

// File: rtl/spi_cmd_validator.sv
module spi_cmd_validator #(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_BYTES  = 3,
   parameter int CNT_W       = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    spi_cs_n,
   input  logic                    spi_sck,
   input  logic                    spi_mosi,
   input  logic                    busy,
   output logic                    exec_stb,
   output logic                    rej_stb,
   output logic [7:0]              cmd_op,
   output logic [8*ADDR_BYTES-1:0] cmd_addr,
   output logic [CNT_W-4:0]        cmd_nbytes
);
   if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_addr
      $error("spi_cmd_validator: ADDR_BYTES must be 1..4");
   end
   if ((1 << (CNT_W - 3)) <= ADDR_BYTES + 2) begin : g_bad_cnt
      $error("spi_cmd_validator: CNT_W too small for the longest rule");
   end

   logic                    sel, bit_rise, mosi_s, end_pulse, idle;
   logic [CNT_W-1:0]        nbits;
   logic [7:0]              op_cap;
   logic [8*ADDR_BYTES-1:0] addr_cap;

   spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
      .sel_o(sel), .sck_rise_o(bit_rise), .mosi_o(mosi_s),
      .end_o(end_pulse), .idle_o(idle)
   );

   spi_frame_shifter #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .clear_i(idle), .bit_i(bit_rise), .mosi_i(mosi_s),
      .nbits_o(nbits), .op_o(op_cap), .addr_o(addr_cap)
   );

   spi_frame_judge #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_judge (
      .clk(clk), .rst_n(rst_n),
      .end_i(end_pulse), .busy_i(busy),
      .nbits_i(nbits), .op_i(op_cap), .addr_i(addr_cap),
      .exec_o(exec_stb), .rej_o(rej_stb),
      .op_o(cmd_op), .addr_o(cmd_addr), .nbytes_o(cmd_nbytes)
   );

   logic unused_sel;
   assign unused_sel = sel;
endmodule

// File: rtl/spi_cmd_validator_chk.sv
module spi_cmd_validator_chk #(
   parameter int NB_W = 9
) (
   input logic            clk,
   input logic            rst_n,
   input logic            end_pulse,
   input logic            busy,
   input logic            exec_stb,
   input logic            rej_stb,
   input logic [7:0]      cmd_op,
   input logic [NB_W-1:0] cmd_nbytes
);
   logic is_erase, is_prog, is_array;
   assign is_erase = (cmd_op == 8'h20) || (cmd_op == 8'hD8);
   assign is_prog  = (cmd_op == 8'h02);
   assign is_array = is_erase || is_prog || (cmd_op == 8'h03) ||
                     (cmd_op == 8'h0B) || (cmd_op == 8'hC7);

   a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(exec_stb && rej_stb));
   a_r2_exec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb |=> !exec_stb);
   a_r2_rej_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rej_stb |=> !rej_stb);
   a_r2_only_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_stb || rej_stb) |-> $past(end_pulse));
   a_r2_end_answered: assert property (@(posedge clk) disable iff (!rst_n)
      end_pulse |=> (exec_stb || rej_stb));
   a_r6_erase_len: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_stb && is_erase) |-> (cmd_nbytes == NB_W'(3)));
   a_r7_prog_len: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_stb && is_prog) |-> (cmd_nbytes >= NB_W'(4)));
   a_r9_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_stb && is_array) |-> !$past(busy));
endmodule

bind spi_cmd_validator spi_cmd_validator_chk #(.NB_W(CNT_W - 3)) u_chk (
   .clk(clk), .rst_n(rst_n), .end_pulse(end_pulse), .busy(busy),
   .exec_stb(exec_stb), .rej_stb(rej_stb),
   .cmd_op(cmd_op), .cmd_nbytes(cmd_nbytes)
);

// File: tb/spi_cmd_validator_bench.sv
module spi_cmd_validator_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
   logic        exec_stb, rej_stb;
   logic [7:0]  cmd_op;
   logic [23:0] cmd_addr;
   logic [8:0]  cmd_nbytes;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic        ex;
      logic [7:0]  op;
      logic [23:0] addr;
      logic [8:0]  nb;
   } exp_t;
   exp_t  sb_q[$];
   string tag_q[$];
   logic [7:0] fbuf [0:7];

   always #5 clk = ~clk;

   spi_cmd_validator u_spi_cmd_validator (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
      .spi_mosi(mosi), .busy(busy), .exec_stb(exec_stb), .rej_stb(rej_stb),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_nbytes(cmd_nbytes)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && (exec_stb || rej_stb)) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R2 unexpected strobe", {exec_stb, rej_stb}, 0);
         end else begin
            exp_t e;
            string t;
            e = sb_q.pop_front();
            t = tag_q.pop_front();
            check(exec_stb == e.ex && rej_stb == !e.ex, t, {exec_stb, rej_stb},
                  {e.ex, !e.ex});
            if (e.ex && exec_stb)
               check(cmd_op == e.op && cmd_addr == e.addr && cmd_nbytes == e.nb,
                     {t, " fields"}, {cmd_op, cmd_addr, cmd_nbytes},
                     {e.op, e.addr, e.nb});
         end
      end
   end

   task automatic ticks(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic load(input logic [7:0] b0, b1, b2, b3, b4, b5);
      fbuf[0] = b0; fbuf[1] = b1; fbuf[2] = b2;
      fbuf[3] = b3; fbuf[4] = b4; fbuf[5] = b5;
   endtask

   task automatic spi_frame(input int nbits);
      cs_n = 1'b0;
      ticks(4);
      for (int i = 0; i < nbits; i++) begin
         mosi = fbuf[i / 8][7 - (i % 8)];
         ticks(4);
         sck = 1'b1;
         ticks(4);
         sck = 1'b0;
      end
      ticks(4);
      cs_n = 1'b1;
      ticks(14);
   endtask

   task automatic expect_frame(input logic ex, input logic [7:0] op,
                               input logic [23:0] addr, input int nb,
                               input string tag, input int nbits);
      exp_t e;
      e.ex = ex; e.op = op; e.addr = addr; e.nb = 9'(nb);
      sb_q.push_back(e);
      tag_q.push_back(tag);
      spi_frame(nbits);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      ticks(5);
      rst_n = 1'b1;
      ticks(3);
      // R11 reset state
      check(!exec_stb && !rej_stb && cmd_op == 0 && cmd_addr == 0 && cmd_nbytes == 0,
            "R11 reset outputs", {exec_stb, rej_stb, cmd_op, cmd_addr, cmd_nbytes}, 0);

      // R4 plain write commands on and off byte boundary
      load(8'h06, 0, 0, 0, 0, 0);
      expect_frame(1, 8'h06, 0, 0, "R4 WREN 8 clocks", 8);
      expect_frame(0, 0, 0, 0, "R4 WREN 9 clocks", 9);
      load(8'hC7, 0, 0, 0, 0, 0);
      expect_frame(1, 8'hC7, 0, 0, "R4 chip erase 8 clocks", 8);
      expect_frame(0, 0, 0, 0, "R4 chip erase 12 clocks", 12);
      load(8'hB9, 8'h11, 0, 0, 0, 0);
      expect_frame(1, 8'hB9, 24'h11, 1, "R4 power-down 16 clocks", 16);

      // R1 R5 read cut mid-byte: 51 clocks -> 6 whole bytes, 5 after opcode
      load(8'h03, 8'h12, 8'h34, 8'h56, 8'hAA, 8'hFF);
      expect_frame(1, 8'h03, 24'h123456, 5, "R1 R5 read mid-byte", 51);
      load(8'hAB, 8'h80, 0, 0, 0, 0);
      expect_frame(1, 8'hAB, 0, 0, "R5 wake 13 clocks", 13);
      load(8'h0B, 8'h00, 8'h00, 8'h10, 8'h00, 0);
      expect_frame(1, 8'h0B, 24'h000010, 4, "R5 fast read 40 clocks", 40);

      // R3 short frame and unknown opcode
      load(8'h03, 0, 0, 0, 0, 0);
      expect_frame(0, 0, 0, 0, "R3 five clocks", 5);
      load(8'h9F, 0, 0, 0, 0, 0);
      expect_frame(0, 0, 0, 0, "R3 unknown opcode", 8);

      // R6 erase lengths
      load(8'h20, 8'hAB, 8'hCD, 8'hEF, 8'h01, 0);
      expect_frame(1, 8'h20, 24'hABCDEF, 3, "R6 sector erase exact", 32);
      expect_frame(0, 0, 0, 0, "R6 sector erase short", 24);
      expect_frame(0, 0, 0, 0, "R6 sector erase long", 40);
      load(8'hD8, 8'h1F, 8'h00, 8'h00, 0, 0);
      expect_frame(1, 8'hD8, 24'h1F0000, 3, "R6 block erase exact", 32);

      // R7 program lengths, R4 partial byte
      load(8'h02, 8'h00, 8'h01, 8'h00, 8'h5A, 8'hA5);
      expect_frame(1, 8'h02, 24'h000100, 4, "R7 program one data byte", 40);
      expect_frame(1, 8'h02, 24'h000100, 5, "R7 program two data bytes", 48);
      expect_frame(0, 0, 0, 0, "R7 program no data", 32);
      expect_frame(0, 0, 0, 0, "R4 program partial byte", 44);

      // R8 status write
      load(8'h01, 8'h5A, 0, 0, 0, 0);
      expect_frame(1, 8'h01, 24'h00005A, 1, "R8 status write one byte", 16);
      expect_frame(0, 0, 0, 0, "R8 status write no byte", 8);

      // R9 busy
      busy = 1'b1;
      load(8'h03, 8'h00, 8'h00, 8'h00, 0, 0);
      expect_frame(0, 0, 0, 0, "R9 read while busy", 32);
      load(8'h20, 8'h01, 8'h00, 8'h00, 0, 0);
      expect_frame(0, 0, 0, 0, "R9 erase while busy", 32);
      load(8'h05, 0, 0, 0, 0, 0);
      expect_frame(1, 8'h05, 0, 0, "R9 status read while busy", 8);
      busy = 1'b0;

      // R10 clocks while deselected
      mosi = 1'b1;
      for (int k = 0; k < 5; k++) begin
         sck = 1'b1; ticks(4);
         sck = 1'b0; ticks(4);
      end
      load(8'h04, 0, 0, 0, 0, 0);
      expect_frame(1, 8'h04, 0, 0, "R10 deselected clocks ignored", 8);

      ticks(10);
      check(sb_q.size() == 0, "R2 every frame answered", sb_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule